// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block makes the serial clock of an I2C master. A free-running system clock is first divided by a prescaler to give a slower module tick. The generator then builds each SCL low period and each SCL high period out of a whole number of module ticks. That number is taken from a pair of divider inputs, plus a small offset that depends on the prescaler setting. The prescaler setting is captured only while the block is disabled.

SCL is treated as a wired-AND line. The block can only pull the line low; to release it, the open-drain enable is turned off. The returned line is passed through a two-flop synchronizer, and the block counts its high period only after that synchronized copy reads high. A slave that stretches the clock, or a second master that holds SCL low, therefore lengthens the high period. If another master pulls the line low during the high phase, the block starts its own low period at once.

The transfer logic can raise a hold request that keeps SCL low for as long as it stays asserted. The block also returns single-cycle strobes on the rising and falling edges of the synchronized line.

Top module: `scl_clock_gen`

## Requirements
- R1: While `rst` is high or `en` is low, `scl_oe` is 0 (line released), and the rise and fall strobes stay 0 while the line stays high.
- R2: One module tick lasts `psc_val + 1` system clocks. The value used is the one present while `en` was low; changing `psc_val` while `en` is high has no effect on any period.
- R3: With no hold request, each driven-low period (`scl_oe` = 1) lasts (`low_div` + d) × (p + 1) system clocks, where p is the captured prescaler value.
- R4: d is 7 when p = 0, 6 when p = 1, and 5 when p is 2 or more.
- R5: The high count of (`high_div` + d) ticks starts only on the cycle after the synchronized line reads high. Seen on an undisturbed line, one released period lasts (`high_div` + d) × (p + 1) + 3 system clocks.
- R6: If something outside the block holds SCL low after release (clock stretching), the high count waits. The line then stays high for (`high_div` + d) × (p + 1) + 2 system clocks after it is let go.
- R7: If the synchronized line goes low during the high count, the block starts its own low period at once. After an external low pulse begins, the line stays low for (`low_div` + d) × (p + 1) + 2 system clocks.
- R8: While `hold_low` is high, a low period that has used up its count keeps `scl_oe` at 1. Once `hold_low` falls, the line is released on the next module tick.
- R9: `scl_rise` and `scl_fall` each pulse for one cycle per rising or falling edge of the synchronized line, and their totals match the edges on the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low keeps the generator in its reset state and opens the prescaler for loading |
| psc_val | input | 8 | Prescaler value p (tick = p + 1 system clocks) |
| low_div | input | 16 | Low-period divider |
| high_div | input | 16 | High-period divider |
| hold_low | input | 1 | Request from the transfer logic to keep SCL low |
| scl_in | input | 1 | Returned SCL line (asynchronous) |
| scl_oe | output | 1 | Open-drain enable: 1 pulls SCL low, 0 releases it |
| scl_rise | output | 1 | One-cycle strobe on a rising edge of the synchronized line |
| scl_fall | output | 1 | One-cycle strobe on a falling edge of the synchronized line |

## Verification
Some rules are checked by assertions on every cycle. The line is released whenever the block is disabled. The captured prescaler does not change while enabled. A pending hold keeps the line low. The line is released only after a low count has run out. The edge strobes never repeat on consecutive cycles.

The exact period lengths need the bench's scenarios. These cover the offset for each prescaler range, the extra synchronizer cycles, the lengthened high time under stretching, and the low period restarted by another master. The bench measures them as run lengths on a modelled wired-AND line.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_HIGH = 2'd2,
        PH_LOW  = 2'd3
    } scl_phase_e;

    // Fixed period offset chosen by the prescaler range
    function automatic logic [2:0] phase_offset(input int unsigned psc);
        if (psc == 0)      return 3'd7;
        else if (psc == 1) return 3'd6;
        else               return 3'd5;
    endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PSC_W-1:0] psc_in,
    input  logic             clr,
    output logic [PSC_W-1:0] psc_q,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_q <= '0;
        end else if (!en) begin
            psc_q <= psc_in;
        end
    end

    assign tick = en && (pcnt_q == psc_q);

    always_ff @(posedge clk) begin
        if (rst || !en || clr) begin
            pcnt_q <= '0;
        end else if (pcnt_q == psc_q) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // R2
    psc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(rst)) |-> (psc_q == $past(psc_q)));

endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_s,
    output logic rise_stb,
    output logic fall_stb
);
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= 3'b111;
        end else begin
            sh_q <= {sh_q[1:0], line_in};
        end
    end

    assign line_s   = sh_q[1];
    assign rise_stb = sh_q[1] & ~sh_q[2];
    assign fall_stb = ~sh_q[1] & sh_q[2];

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise_stb |=> !rise_stb);

    // R9
    fall_single_chk: assert property (@(posedge clk) disable iff (rst)
        fall_stb |=> !fall_stb);

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
    import scl_gen_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [PSC_W-1:0] psc_q,
    input  logic [DIV_W-1:0] low_div,
    input  logic [DIV_W-1:0] high_div,
    input  logic             hold_low,
    input  logic             line_s,
    output logic             presc_clr,
    output logic             drive_low
);
    localparam int CW = DIV_W + 1;

    scl_phase_e       phase_q, phase_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [CW-1:0]    lim_low, lim_high, offs;

    assign offs     = CW'(phase_offset(int'(psc_q)));
    assign lim_low  = {1'b0, low_div} + offs;
    assign lim_high = {1'b0, high_div} + offs;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE: begin
                phase_d = PH_WAIT;
                cnt_d   = '0;
            end
            PH_WAIT: begin
                if (line_s) begin
                    phase_d = PH_HIGH;
                    cnt_d   = '0;
                end
            end
            PH_HIGH: begin
                if (!line_s) begin
                    phase_d = PH_LOW;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_q >= lim_high - 1'b1) begin
                        phase_d = PH_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PH_LOW: begin
                if (tick) begin
                    if (cnt_q >= lim_low - 1'b1) begin
                        if (!hold_low) begin
                            phase_d = PH_WAIT;
                            cnt_d   = '0;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
        if (!en) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign presc_clr = (phase_d != phase_q) || (phase_d == PH_WAIT) || (phase_d == PH_IDLE);
    assign drive_low = (phase_q == PH_LOW);

    // R1
    off_release_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !drive_low);

    // R8
    hold_keeps_low_chk: assert property (@(posedge clk) disable iff (rst)
        (en && drive_low && hold_low) |=> (drive_low || !en));

    // R3
    full_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(drive_low) && en && $past(en) && !$past(rst))
        |-> ($past(cnt_q) >= $past(lim_low) - 1'b1));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import scl_gen_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PSC_W-1:0] psc_val,
    input  logic [DIV_W-1:0] low_div,
    input  logic [DIV_W-1:0] high_div,
    input  logic             hold_low,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             scl_rise,
    output logic             scl_fall
);
    logic [PSC_W-1:0] psc_q;
    logic             tick;
    logic             presc_clr;
    logic             line_s;

    scl_prescaler #(.PSC_W(PSC_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .psc_in (psc_val),
        .clr    (presc_clr),
        .psc_q  (psc_q),
        .tick   (tick)
    );

    scl_line_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_in  (scl_in),
        .line_s   (line_s),
        .rise_stb (scl_rise),
        .fall_stb (scl_fall)
    );

    scl_phase_ctrl #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .tick      (tick),
        .psc_q     (psc_q),
        .low_div   (low_div),
        .high_div  (high_div),
        .hold_low  (hold_low),
        .line_s    (line_s),
        .presc_clr (presc_clr),
        .drive_low (scl_oe)
    );

endmodule

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb;

    typedef struct {
        bit    level;
        int    width;
        string req;
    } run_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [7:0]  psc_val = 8'd0;
    logic [15:0] low_div = 16'd3;
    logic [15:0] high_div = 16'd2;
    logic        hold_low = 1'b0;
    logic        ext_low = 1'b0;
    logic        scl_oe, scl_rise, scl_fall;
    wire         scl_line = !(scl_oe | ext_low);

    int checks = 0;
    int errors = 0;
    run_item_t exp_q[$];
    int  pending = 0;
    bit  arm = 1'b0;
    bit  mon_on = 1'b0;
    int  line_rises = 0, line_falls = 0, st_rises = 0, st_falls = 0;

    always #5 clk = ~clk;

    scl_clock_gen u_dut (
        .clk(clk), .rst(rst), .en(en), .psc_val(psc_val),
        .low_div(low_div), .high_div(high_div), .hold_low(hold_low),
        .scl_in(scl_line), .scl_oe(scl_oe), .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input bit lvl, input int w, input string req);
        run_item_t it;
        it.level = lvl; it.width = w; it.req = req;
        exp_q.push_back(it);
        pending++;
    endtask

    task automatic arm_and_wait();
        arm = 1'b1;
        wait (mon_on);
    endtask

    task automatic sample();
        @(posedge clk); #2;
    endtask

    // Monitor: measures run lengths of the wired-AND line and scores them
    initial begin : monitor
        bit last = 1'b1;
        int run = 0;
        forever begin
            @(posedge clk); #2;
            if (!rst) begin
                if (scl_line && !last) line_rises++;
                if (!scl_line && last) line_falls++;
                if (scl_rise) st_rises++;
                if (scl_fall) st_falls++;
                if (scl_line == last) begin
                    run++;
                end else begin
                    if (mon_on && exp_q.size() > 0) begin
                        run_item_t it;
                        it = exp_q.pop_front();
                        pending--;
                        chk((it.level == last) && (it.width < 0 || it.width == run),
                            it.req, run, it.width);
                        if (exp_q.size() == 0) mon_on = 1'b0;
                    end
                    if (arm && !scl_line) begin
                        mon_on = 1'b1;
                        arm = 1'b0;
                    end
                    run = 1;
                end
                last = scl_line;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic reconfig(input logic [7:0] p);
        @(negedge clk); en = 1'b0;
        repeat (4) begin
            sample();
            chk(scl_oe == 1'b0, "R1 disabled", scl_oe, 0);
        end
        @(negedge clk); psc_val = p;
        @(negedge clk); en = 1'b1;
    endtask

    initial begin : driver
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk(scl_oe == 1'b0, "R1 reset oe", scl_oe, 0);
        @(negedge clk); rst = 1'b0;
        repeat (3) begin
            sample();
            chk(scl_oe == 1'b0 && !scl_rise && !scl_fall, "R1 idle", scl_oe, 0);
        end

        // R3 R4 R5: p=0, d=7 -> low 10, released 9+3
        @(negedge clk); en = 1'b1;
        push(0, 10, "R3 low p0"); push(1, 12, "R5 high p0");
        push(0, 10, "R3 low p0"); push(1, 12, "R5 high p0");
        arm_and_wait(); wait (pending == 0);

        // R2: changing prescaler while enabled has no effect
        @(negedge clk); psc_val = 8'd3;
        push(0, 10, "R2 psc ignored"); push(1, 12, "R2 psc ignored");
        arm_and_wait(); wait (pending == 0);

        // R2 R4: p=1, d=6 -> low 18, released 16+3
        reconfig(8'd1);
        push(0, 18, "R4 low p1"); push(1, 19, "R4 high p1");
        push(0, 18, "R2 low p1");
        arm_and_wait(); wait (pending == 0);

        // R4: p=2, d=5 -> low 24, released 21+3
        reconfig(8'd2);
        push(0, 24, "R4 low p2"); push(1, 24, "R4 high p2");
        arm_and_wait(); wait (pending == 0);

        // R6: clock stretching, p=0
        reconfig(8'd0);
        push(0, -1, "R6 stretched low"); push(1, 11, "R6 high after stretch");
        push(0, 10, "R6 next low"); push(1, 12, "R6 next high");
        arm_and_wait();
        @(negedge clk); ext_low = 1'b1;
        do sample(); while (scl_oe);
        repeat (5) @(negedge clk);
        ext_low = 1'b0;
        wait (pending == 0);

        // R7: another master pulls low during the high count
        push(0, 10, "R7 low"); push(1, -1, "R7 cut high");
        push(0, 12, "R7 synced low"); push(1, 12, "R7 high");
        arm_and_wait();
        do sample(); while (scl_oe);
        repeat (4) @(negedge clk);
        ext_low = 1'b1;
        repeat (3) @(negedge clk);
        ext_low = 1'b0;
        wait (pending == 0);

        // R8: hold request keeps the line low
        do sample(); while (scl_oe);
        @(negedge clk); hold_low = 1'b1;
        push(0, -1, "R8 held low"); push(1, 12, "R8 high after hold");
        arm_and_wait();
        repeat (30) begin
            sample();
            chk(scl_oe == 1'b1, "R8 held", scl_oe, 1);
        end
        @(negedge clk); hold_low = 1'b0;
        sample();
        chk(scl_oe == 1'b0, "R8 released", scl_oe, 0);
        wait (pending == 0);

        // R1 R9: disable, line settles high, strobe totals match line edges
        @(negedge clk); en = 1'b0;
        repeat (6) sample();
        chk(scl_oe == 1'b0 && !scl_rise && !scl_fall, "R1 off quiet", scl_oe, 0);
        chk(st_rises == line_rises, "R9 rise count", st_rises, line_rises);
        chk(st_falls == line_falls, "R9 fall count", st_falls, line_falls);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule